// File: doc/BRIEF.md
# Panel Controller Register Interface

This block is the register interface of a display-panel controller that software reaches over I2C. An I2C slave front end hands it one byte at a time. A write transaction opens with a byte that sets the register pointer. Each later byte of the same transaction is written at the pointer, and the pointer then moves up by one. Reads do not use that pointer. Software first writes a start address into the read-address register. Every byte read after that is either the current read address or the data held at that address, and the two alternate. The address moves up by one after each such pair.

Two factory register sets are normally hidden. Each opens when a magic value is written to its key register. While a set is open, its bytes take the place of the standard registers at the same addresses. The block also holds a display-enable register, a fixed controller identifier and a ready flag. It has a checksum register that is refreshed when a trigger bit rises, and it drives panel configuration outputs for enable, scan flips, colour swap and interlace.

Top module: `panel_ctl_regif`

## Requirements
- R1: After the read address is set to A, successive read bytes are A, data(A), A+1, data(A+1) and so on. The address wraps from 0xFF to 0x00, and each byte is consumed by one `rd_next` pulse.
- R2: In a write transaction (`wr_valid` with `wr_start`=1), the first byte loads the pointer. Each following byte (`wr_start`=0) writes to the pointer, and the pointer then increments by one.
- R3: Register 0x01 keeps only the bits in mask 0x11. `panel_on` is bit 4. `panel_input_ignored` is high only for the value 0x11.
- R4: Writing 0xAA to 0xAF opens factory set A, and writing 0xAA to 0x03 opens factory set B. Writing any other value to a key closes its set. Both keys read as 0x00.
- R5: While set A is open, addresses FA_BASE to FA_BASE+FA_DEPTH-1 (default 0x50 to 0x57) read and write eight full-width factory bytes instead of the standard registers. Once set A is closed, those addresses reach the standard registers again, and the factory bytes keep their contents.
- R6: While set B is open, 0x10 is image control with mask 0xD7, and its bit 0 drives `color_invert`. Also while set B is open, 0x11 is the transform register with mask 0x7F: bit 0 hflip, bit 1 red/blue swap, bit 2 vflip, bit 3 line-pair swap, bit 4 interlace. While set B is closed, both addresses read 0x00 and writes to them are dropped, but the outputs keep their values.
- R7: Register 0x40 sets the read address and resets the pair phase whether or not a factory set is open. It reads as 0x00.
- R8: A write to 0x54 (mask 0x01) that takes bit 0 from 0 to 1 loads 0x56 with the XOR of registers 0x01, 0x10, 0x11, 0x60 and the controller ID, and sets 0x55 to 0x01. A write that leaves bit 0 at 1, or clears it, changes neither register.
- R9: Registers 0x55, 0x56, 0x62 and 0xFF ignore writes. 0xFF reads the CTRL_ID parameter, with the manufacturer code in the upper nibble and the revision in the lower nibble.
- R10: Register 0x62 reads 0x00 until INIT_CYCLES clocks after the internal reset release, and reads 0x01 from then on.
- R11: Register 0x60 keeps only mask 0x01. Unmapped addresses read 0x00 and discard writes.
- R12: After reset, all writable registers are 0x00, both factory sets are closed, 0x55 is 0x00, and the read sequence starts at address 0x00 in the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_valid | input | 1 | A written byte is presented this cycle |
| wr_start | input | 1 | The presented byte is the first byte of a write transaction (pointer) |
| wr_data | input | 8 | Written byte |
| rd_next | input | 1 | The current read byte has been taken; advance the read sequence |
| rd_data | output | 8 | Current read byte (address or data, by phase) |
| panel_on | output | 1 | Panel enabled |
| panel_input_ignored | output | 1 | Panel on with the colour input ignored |
| color_invert | output | 1 | Colour inversion |
| hflip | output | 1 | Horizontal scan flip |
| rb_swap | output | 1 | Red/blue swap |
| vflip | output | 1 | Vertical scan flip |
| pair_swap | output | 1 | Swap the order of each scanline pair |
| interlace | output | 1 | Interlaced output |

## Verification
The bench builds the block with INIT_CYCLES=40, FA_BASE=0x50, FA_DEPTH=8 and CTRL_ID=0xC3. The short ready delay lets the ready register be read both before and after it flips within a brief run. The factory window is placed over 0x54 to 0x56, so a factory set that is open provably hides the checksum trigger and its results. A non-default identifier shows that 0xFF and the checksum both follow the parameter. With the read address set at 0xFF, the read sequence shows the wrap to 0x00.

// File: rtl/panel_ctl_pkg.sv
package panel_ctl_pkg;
  localparam logic [7:0] A_DISP_EN = 8'h01;
  localparam logic [7:0] A_KEY_B   = 8'h03;
  localparam logic [7:0] A_IMG_CTL = 8'h10;
  localparam logic [7:0] A_XFORM   = 8'h11;
  localparam logic [7:0] A_RD_ADDR = 8'h40;
  localparam logic [7:0] A_CK_TRIG = 8'h54;
  localparam logic [7:0] A_CK_STAT = 8'h55;
  localparam logic [7:0] A_CK_VAL  = 8'h56;
  localparam logic [7:0] A_SPARE   = 8'h60;
  localparam logic [7:0] A_READY   = 8'h62;
  localparam logic [7:0] A_KEY_A   = 8'hAF;
  localparam logic [7:0] A_CTRL_ID = 8'hFF;

  localparam logic [7:0] M_DISP_EN = 8'h11;
  localparam logic [7:0] M_IMG_CTL = 8'hD7;
  localparam logic [7:0] M_XFORM   = 8'h7F;
  localparam logic [7:0] M_CK_TRIG = 8'h01;
  localparam logic [7:0] M_SPARE   = 8'h01;
  localparam logic [7:0] KEY_OPEN  = 8'hAA;

  typedef struct packed {
    logic       en;
    logic [7:0] addr;
    logic [7:0] data;
  } wr_op_t;

  typedef struct packed {
    logic on;
    logic ignore_in;
    logic cinv;
    logic hflip;
    logic rbsw;
    logic vflip;
    logic pairsw;
    logic ilace;
  } panel_cfg_t;
endpackage

// File: rtl/pcr_read_seq.sv
module pcr_read_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_addr,
  input  logic       step,
  output logic [7:0] cur_addr,
  output logic       data_phase
);
  logic [7:0] addr_q, addr_d;
  logic       phase_q, phase_d;
  logic       upd;

  always_comb begin
    addr_d  = addr_q;
    phase_d = phase_q;
    if (load) begin
      addr_d  = load_addr;
      phase_d = 1'b0;
    end else if (step) begin
      phase_d = ~phase_q;
      if (phase_q) addr_d = addr_q + 8'd1;
    end
  end

  assign upd = load | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      phase_q <= 1'b0;
    end else if (upd) begin
      addr_q  <= addr_d;
      phase_q <= phase_d;
    end
  end

  assign cur_addr   = addr_q;
  assign data_phase = phase_q;
endmodule

// File: rtl/pcr_key_gate.sv
module pcr_key_gate
  import panel_ctl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  wr_op_t wr,
  output logic   open_a,
  output logic   open_b
);
  logic a_q, a_d, b_q, b_d, hit;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    if (wr.en && wr.addr == A_KEY_A) a_d = (wr.data == KEY_OPEN);
    if (wr.en && wr.addr == A_KEY_B) b_d = (wr.data == KEY_OPEN);
  end

  assign hit = wr.en && (wr.addr == A_KEY_A || wr.addr == A_KEY_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else if (hit) begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign open_a = a_q;
  assign open_b = b_q;
endmodule

// File: rtl/pcr_init_timer.sv
module pcr_init_timer #(
  parameter int INIT_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int CW = $clog2(INIT_CYCLES + 2);
  localparam logic [CW-1:0] LIMIT = CW'(INIT_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run;

  assign run   = (cnt_q != LIMIT);
  assign cnt_d = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_d;
  end

  assign done = ~run;
endmodule

// File: rtl/pcr_regfile.sv
module pcr_regfile
  import panel_ctl_pkg::*;
#(
  parameter int         FA_BASE  = 'h50,
  parameter int         FA_DEPTH = 8,
  parameter logic [7:0] CTRL_ID  = 8'hC7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  wr_op_t     wr,
  input  logic [7:0] rd_addr,
  input  logic       open_a,
  input  logic       open_b,
  input  logic       init_done,
  output logic [7:0] rd_val,
  output panel_cfg_t cfg
);
  localparam logic [8:0] FA_LO = 9'(FA_BASE);
  localparam logic [8:0] FA_HI = 9'(FA_BASE + FA_DEPTH);

  function automatic logic in_fa(input logic [7:0] a);
    return ({1'b0, a} >= FA_LO) && ({1'b0, a} < FA_HI);
  endfunction

  logic       wa_fa, ra_fa, std_wr;
  logic [7:0] wa_off, ra_off;

  assign wa_fa  = open_a && in_fa(wr.addr);
  assign ra_fa  = open_a && in_fa(rd_addr);
  assign wa_off = wr.addr - FA_LO[7:0];
  assign ra_off = rd_addr - FA_LO[7:0];
  assign std_wr = wr.en && !wa_fa;

  // factory set A storage
  logic [7:0] fa_v [FA_DEPTH];
  generate
    for (genvar g = 0; g < FA_DEPTH; g++) begin : g_fa
      logic [7:0] q;
      logic       we;
      assign we = wr.en && wa_fa && (wa_off == 8'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wr.data;
      end
      assign fa_v[g] = q;
    end
  endgenerate

  // standard and set-B registers
  logic [7:0] disp_q, img_q, xf_q, trig_q, stat_q, ck_q, spare_q;
  logic [7:0] disp_d, img_d, xf_d, trig_d, stat_d, ck_d, spare_d;
  logic       fire;

  always_comb begin
    disp_d  = disp_q;
    img_d   = img_q;
    xf_d    = xf_q;
    trig_d  = trig_q;
    stat_d  = stat_q;
    ck_d    = ck_q;
    spare_d = spare_q;
    fire    = 1'b0;
    if (std_wr) begin
      case (wr.addr)
        A_DISP_EN: disp_d = wr.data & M_DISP_EN;
        A_IMG_CTL: if (open_b) img_d = wr.data & M_IMG_CTL;
        A_XFORM:   if (open_b) xf_d = wr.data & M_XFORM;
        A_CK_TRIG: begin
          trig_d = wr.data & M_CK_TRIG;
          fire   = wr.data[0] & ~trig_q[0];
        end
        A_SPARE:   spare_d = wr.data & M_SPARE;
        default: ;
      endcase
    end
    if (fire) begin
      ck_d   = disp_q ^ img_q ^ xf_q ^ spare_q ^ CTRL_ID;
      stat_d = 8'h01;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q  <= '0;
      img_q   <= '0;
      xf_q    <= '0;
      trig_q  <= '0;
      stat_q  <= '0;
      ck_q    <= '0;
      spare_q <= '0;
    end else if (std_wr) begin
      disp_q  <= disp_d;
      img_q   <= img_d;
      xf_q    <= xf_d;
      trig_q  <= trig_d;
      stat_q  <= stat_d;
      ck_q    <= ck_d;
      spare_q <= spare_d;
    end
  end

  always_comb begin
    rd_val = '0;
    if (ra_fa) begin
      for (int i = 0; i < FA_DEPTH; i++)
        if (ra_off == 8'(i)) rd_val = fa_v[i];
    end else begin
      case (rd_addr)
        A_DISP_EN: rd_val = disp_q;
        A_IMG_CTL: rd_val = open_b ? img_q : 8'h00;
        A_XFORM:   rd_val = open_b ? xf_q : 8'h00;
        A_CK_TRIG: rd_val = trig_q;
        A_CK_STAT: rd_val = stat_q;
        A_CK_VAL:  rd_val = ck_q;
        A_SPARE:   rd_val = spare_q;
        A_READY:   rd_val = {7'd0, init_done};
        A_CTRL_ID: rd_val = CTRL_ID;
        default:   rd_val = 8'h00;
      endcase
    end
  end

  assign cfg.on        = disp_q[4];
  assign cfg.ignore_in = disp_q[4] & disp_q[0];
  assign cfg.cinv      = img_q[0];
  assign cfg.hflip     = xf_q[0];
  assign cfg.rbsw      = xf_q[1];
  assign cfg.vflip     = xf_q[2];
  assign cfg.pairsw    = xf_q[3];
  assign cfg.ilace     = xf_q[4];
endmodule

// File: rtl/panel_ctl_regif.sv
module panel_ctl_regif
  import panel_ctl_pkg::*;
#(
  parameter int         INIT_CYCLES = 1000,
  parameter int         FA_BASE     = 'h50,
  parameter int         FA_DEPTH    = 8,
  parameter logic [7:0] CTRL_ID     = 8'hC7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic       wr_start,
  input  logic [7:0] wr_data,
  input  logic       rd_next,
  output logic [7:0] rd_data,
  output logic       panel_on,
  output logic       panel_input_ignored,
  output logic       color_invert,
  output logic       hflip,
  output logic       rb_swap,
  output logic       vflip,
  output logic       pair_swap,
  output logic       interlace
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  // write pointer
  logic [7:0] ptr_q, ptr_d;
  always_comb begin
    ptr_d = ptr_q;
    if (wr_start) ptr_d = wr_data;
    else          ptr_d = ptr_q + 8'd1;
  end
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)        ptr_q <= '0;
    else if (wr_valid) ptr_q <= ptr_d;
  end

  wr_op_t wr_op;
  assign wr_op.en   = wr_valid & ~wr_start;
  assign wr_op.addr = ptr_q;
  assign wr_op.data = wr_data;

  logic       rd_load, rd_phase, open_a, open_b, init_done;
  logic [7:0] rd_cur, rd_val;
  panel_cfg_t cfg;

  assign rd_load = wr_op.en && (ptr_q == A_RD_ADDR);

  pcr_read_seq u_seq (
    .clk(clk), .rst_n(rst_i), .load(rd_load), .load_addr(wr_data),
    .step(rd_next), .cur_addr(rd_cur), .data_phase(rd_phase)
  );

  pcr_key_gate u_keys (
    .clk(clk), .rst_n(rst_i), .wr(wr_op), .open_a(open_a), .open_b(open_b)
  );

  pcr_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk(clk), .rst_n(rst_i), .done(init_done)
  );

  pcr_regfile #(.FA_BASE(FA_BASE), .FA_DEPTH(FA_DEPTH), .CTRL_ID(CTRL_ID)) u_regs (
    .clk(clk), .rst_n(rst_i), .wr(wr_op), .rd_addr(rd_cur),
    .open_a(open_a), .open_b(open_b), .init_done(init_done),
    .rd_val(rd_val), .cfg(cfg)
  );

  assign rd_data             = rd_phase ? rd_val : rd_cur;
  assign panel_on            = cfg.on;
  assign panel_input_ignored = cfg.ignore_in;
  assign color_invert        = cfg.cinv;
  assign hflip               = cfg.hflip;
  assign rb_swap             = cfg.rbsw;
  assign vflip               = cfg.vflip;
  assign pair_swap           = cfg.pairsw;
  assign interlace           = cfg.ilace;
endmodule

// File: rtl/pcr_checker.sv
module pcr_checker
  import panel_ctl_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_ptr,
  input logic [7:0] wr_data,
  input logic       rd_next,
  input logic [7:0] rd_cur,
  input logic       rd_phase,
  input logic       open_a,
  input logic       open_b,
  input logic       init_done,
  input logic [4:0] xform_out
);
  logic load;
  assign load = wr_en && (wr_ptr == A_RD_ADDR);

  p_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_next && !load) |=> (rd_phase != $past(rd_phase)));

  p_incr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_next && rd_phase && !load) |=> (rd_cur == $past(rd_cur) + 8'd1));

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (rd_cur == $past(wr_data) && !rd_phase));

  p_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ptr == A_KEY_A && wr_data == KEY_OPEN) |=> open_a);

  p_relock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ptr == A_KEY_B && wr_data != KEY_OPEN) |=> !open_b);

  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !open_b |=> $stable(xform_out));
endmodule

bind panel_ctl_regif pcr_checker u_chk (
  .clk(clk), .rst_n(rst_i), .wr_en(wr_op.en), .wr_ptr(ptr_q), .wr_data(wr_data),
  .rd_next(rd_next), .rd_cur(rd_cur), .rd_phase(rd_phase),
  .open_a(open_a), .open_b(open_b), .init_done(init_done),
  .xform_out({interlace, pair_swap, vflip, rb_swap, hflip})
);

// File: tb/panel_ctl_regif_test.sv
`timescale 1ns/1ps
module panel_ctl_regif_test;
  localparam int         P_INIT = 40;
  localparam int         P_BASE = 'h50;
  localparam int         P_DEP  = 8;
  localparam logic [7:0] P_ID   = 8'hC3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wv = 1'b0, ws = 1'b0, rn = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd_data;
  logic p_on, p_ign, c_inv, hf, rbs, vf, ps, il;

  int total = 0, bad = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  panel_ctl_regif #(.INIT_CYCLES(P_INIT), .FA_BASE(P_BASE), .FA_DEPTH(P_DEP), .CTRL_ID(P_ID)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wv), .wr_start(ws), .wr_data(wd),
    .rd_next(rn), .rd_data(rd_data), .panel_on(p_on), .panel_input_ignored(p_ign),
    .color_invert(c_inv), .hflip(hf), .rb_swap(rbs), .vflip(vf), .pair_swap(ps),
    .interlace(il)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_ptr, m_raddr, m_disp, m_img, m_xf, m_trig, m_stat, m_ck, m_spare;
  logic [7:0] m_fa [P_DEP];
  logic m_ph, m_oa, m_ob;
  int m_since;

  function automatic bit m_in_a(input logic [7:0] a);
    return m_oa && (int'(a) >= P_BASE) && (int'(a) < P_BASE + P_DEP);
  endfunction

  function automatic logic [7:0] m_read(input logic [7:0] a);
    if (m_in_a(a)) return m_fa[int'(a) - P_BASE];
    case (a)
      8'h01: return m_disp;
      8'h10: return m_ob ? m_img : 8'h00;
      8'h11: return m_ob ? m_xf : 8'h00;
      8'h54: return m_trig;
      8'h55: return m_stat;
      8'h56: return m_ck;
      8'h60: return m_spare;
      8'h62: return (m_since >= P_INIT + 2) ? 8'h01 : 8'h00;
      8'hFF: return P_ID;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ptr = 0; m_raddr = 0; m_ph = 0; m_oa = 0; m_ob = 0;
      m_disp = 0; m_img = 0; m_xf = 0; m_trig = 0; m_stat = 0; m_ck = 0; m_spare = 0;
      for (int i = 0; i < P_DEP; i++) m_fa[i] = 0;
      m_since = 0;
    end else begin
      bit loaded;
      logic [7:0] a;
      loaded = 0;
      m_since++;
      if (wv && ws) m_ptr = wd;
      else if (wv) begin
        a = m_ptr;
        if (m_in_a(a)) m_fa[int'(a) - P_BASE] = wd;
        else begin
          case (a)
            8'h01: m_disp = wd & 8'h11;
            8'h03: m_ob = (wd == 8'hAA);
            8'hAF: m_oa = (wd == 8'hAA);
            8'h10: if (m_ob) m_img = wd & 8'hD7;
            8'h11: if (m_ob) m_xf = wd & 8'h7F;
            8'h40: begin m_raddr = wd; m_ph = 0; loaded = 1; end
            8'h54: begin
              if (wd[0] && !m_trig[0]) begin
                m_ck = m_disp ^ m_img ^ m_xf ^ m_spare ^ P_ID;
                m_stat = 8'h01;
              end
              m_trig = wd & 8'h01;
            end
            8'h60: m_spare = wd & 8'h01;
            default: ;
          endcase
        end
        m_ptr = m_ptr + 8'd1;
      end
      if (rn && !loaded) begin
        if (m_ph) m_raddr = m_raddr + 8'd1;
        m_ph = !m_ph;
      end
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!done_flag && m_since >= 0) begin
      check("R1 rd_data vs model", rd_data, m_ph ? m_read(m_raddr) : m_raddr);
      check("R3 display outputs vs model", {6'd0, p_on, p_ign},
            {6'd0, m_disp[4], m_disp[4] & m_disp[0]});
      check("R6 transform outputs vs model", {2'd0, c_inv, il, ps, vf, rbs, hf},
            {2'd0, m_img[0], m_xf[4:0]});
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr_bytes(input logic [7:0] reg_a, input logic [7:0] d0,
                          input int n, input logic [7:0] d1);
    @(negedge clk); wv = 1; ws = 1; wd = reg_a;
    @(negedge clk); ws = 0; wd = d0;
    if (n > 1) begin @(negedge clk); wd = d1; end
    @(negedge clk); wv = 0; wd = 8'h00;
  endtask

  task automatic wr1(input logic [7:0] reg_a, input logic [7:0] d);
    wr_bytes(reg_a, d, 1, 8'h00);
  endtask

  task automatic rd_byte(output logic [7:0] b);
    @(negedge clk); #1 b = rd_data; rn = 1;
    @(negedge clk); rn = 0;
  endtask

  task automatic rd_pair(input logic [7:0] a, input string req, input logic [7:0] exp);
    logic [7:0] b;
    wr1(8'h40, a);
    rd_byte(b); check({req, " address byte"}, b, a);
    rd_byte(b); check({req, " data byte"}, b, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R12 reset state
    check("R12 reset read byte", rd_data, 8'h00);
    check("R12 reset panel_on", {7'd0, p_on}, 8'h00);
    check("R12 reset hflip", {7'd0, hf}, 8'h00);
    // R10 ready before and after delay
    rd_pair(8'h62, "R10 not ready", 8'h00);
    repeat (60) @(negedge clk);
    rd_pair(8'h62, "R10 ready", 8'h01);
    // R3 display enable mask
    wr1(8'h01, 8'hFF);
    rd_pair(8'h01, "R3 mask 0x11", 8'h11);
    check("R3 input ignored", {7'd0, p_ign}, 8'h01);
    wr1(8'h01, 8'h10);
    check("R3 on driven", {6'd0, p_on, p_ign}, 8'h02);
    // R2 and R11 multi-byte write
    wr_bytes(8'h60, 8'hFF, 2, 8'h33);
    rd_pair(8'h60, "R11 spare mask", 8'h01);
    rd_byte(b); check("R1 next address", b, 8'h61);
    rd_byte(b); check("R2 R11 unmapped write dropped", b, 8'h00);
    // R9 identifier and wrap
    wr1(8'hFF, 8'h12);
    rd_pair(8'hFF, "R9 controller id", P_ID);
    rd_byte(b); check("R1 wrap address", b, 8'h00);
    rd_byte(b); check("R1 wrap data", b, 8'h00);
    // R6 set B closed then open
    wr1(8'h11, 8'h1F);
    check("R6 locked write ignored", {7'd0, hf}, 8'h00);
    rd_pair(8'h11, "R6 locked read", 8'h00);
    wr1(8'h03, 8'hAA);
    wr_bytes(8'h10, 8'hFF, 2, 8'hFF);
    rd_pair(8'h10, "R6 image mask", 8'hD7);
    rd_pair(8'h11, "R6 transform mask", 8'h7F);
    check("R6 outputs set", {2'd0, c_inv, il, ps, vf, rbs, hf}, 8'h3F);
    wr1(8'h03, 8'h55);
    rd_pair(8'h11, "R4 relocked B", 8'h00);
    check("R6 outputs kept", {2'd0, il, ps, vf, rbs, hf}, 8'h1F);
    rd_pair(8'h03, "R4 key reads zero", 8'h00);
    // R8 checksum: 0x10^0xD7^0x7F^0x01^0xC3 = 0x7A
    wr1(8'h54, 8'h01);
    rd_pair(8'h55, "R8 status", 8'h01);
    rd_pair(8'h56, "R8 checksum", 8'h7A);
    wr1(8'h01, 8'h11);
    wr1(8'h54, 8'h01);
    rd_pair(8'h56, "R8 no edge no update", 8'h7A);
    wr_bytes(8'h55, 8'hEE, 2, 8'hEE);
    rd_pair(8'h56, "R9 checksum read-only", 8'h7A);
    wr1(8'h54, 8'h00);
    wr1(8'h54, 8'h01);
    rd_pair(8'h56, "R8 new edge", 8'h7B);
    // R5 and R7 factory set A over 0x50..0x57
    wr1(8'hAF, 8'hAA);
    rd_pair(8'h56, "R5 shadow initial", 8'h00);
    wr_bytes(8'h54, 8'hA5, 2, 8'h5A);
    rd_pair(8'h54, "R5 R7 factory byte", 8'hA5);
    rd_byte(b); check("R5 next address", b, 8'h55);
    rd_byte(b); check("R5 factory byte 2", b, 8'h5A);
    wr1(8'hAF, 8'h00);
    rd_pair(8'h56, "R5 standard restored", 8'h7B);
    rd_pair(8'h54, "R5 trigger untouched", 8'h01);
    wr1(8'hAF, 8'hAA);
    rd_pair(8'h54, "R5 factory retained", 8'hA5);
    repeat (4) @(negedge clk);
    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule